// File: doc/BRIEF.md
# Programmable Pin Debounce Filter

This block cleans up one asynchronous pin before it reaches an interrupt detector and a status register. The raw pin and a slow free-running reference clock both enter through synchronisers; each rising edge of the synchronised reference clock becomes a one-cycle tick. Two range bits pick a base period of 2, 8, 512 or 2048 ticks, and a 4-bit count sets how many base periods a new level must persist before the filtered output accepts it.

A 2-bit filter-type field selects the behaviour. It can reject short pulses of either polarity. It can let low pulses through at once while filtering rising changes, for a pin that is active high. It can do the mirror of that, for a pin that is active low. A fourth setting switches filtering off. With the type off, or with a zero count, the synchronised pin goes straight to the output.

The filter is a three-state machine. INIT waits for the synchroniser to fill and takes the first synchronised value (transition LOAD_FIRST). STABLE holds the accepted level: a change that may pass at once is taken on the spot (ACCEPT_NOW), and any other change moves to QUALIFY (START_WINDOW). QUALIFY counts base periods from a freshly cleared prescaler. It returns to STABLE when the pin returns to the accepted level (ABANDON), when the window completes and the new level is taken (COMMIT), or when the configuration now allows immediate passing (ACCEPT_NOW).

Top module: `pin_deglitch`

## Requirements
- R1: While rst_n is low, level_out is 0; after release, level_out takes the synchronised pin value within 4 clock cycles, with no filter window applied.
- R2: With cfg_mode = 0 (filter off), level_out follows pin_async 3 clock edges later, including single-cycle pulses.
- R3: With cfg_mode = 3 (reject both), a change of the synchronised pin reaches level_out only after it has held for cfg_count base periods of ticks, and pulses shorter than that never appear; level_out only ever moves to the synchronised pin value.
- R4: A return of the synchronised pin to the accepted level during a window discards the window, so a later change starts counting again from zero.
- R5: With cfg_mode = 1 (keep low pulses), a falling change reaches level_out 3 clock edges later, while a rising change is filtered as in R3.
- R6: With cfg_mode = 2 (keep high pulses), a rising change reaches level_out 3 clock edges later, while a falling change is filtered as in R3.
- R7: The base period is selected by {cfg_large, cfg_unit}: 00 gives 2 ticks, 01 gives 8, 10 gives 512 and 11 gives 2048, a tick being a rising edge of ref_clk_async.
- R8: With a nonzero cfg_mode and cfg_count = 0, every change passes as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 1 | Raw pin, asynchronous to clk |
| ref_clk_async | input | 1 | Slow reference clock; its rising edges are ticks |
| cfg_count | input | 4 | Window length in base periods |
| cfg_unit | input | 1 | Low range-select bit |
| cfg_large | input | 1 | High range-select bit |
| cfg_mode | input | 2 | 0 off, 1 keep low pulses, 2 keep high pulses, 3 reject both |
| level_out | output | 1 | Filtered pin level |

## Verification
A change that passes at once shows at level_out after three clock edges (two synchroniser flops and the output register), so the bench drives the pin on a falling edge and samples one nanosecond after the third or fourth rising edge. A filtered change lands between 4·N and 4·N+3 edges after the stimulus for N ticks, because the bench reference clock ticks every four cycles with an arbitrary phase against the cleared prescaler. The bench therefore samples three edges before that range, expecting the old level, and six edges after its start, expecting the new one. Pulse and reversal scenarios are timed so that a window that failed to restart would have closed before the later sample.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_STABLE = 2'd1,
        ST_QUAL   = 2'd2
    } pd_state_e;

    typedef enum logic [1:0] {
        FLT_OFF       = 2'd0,
        FLT_KEEP_LOW  = 2'd1,
        FLT_KEEP_HIGH = 2'd2,
        FLT_BOTH      = 2'd3
    } pd_mode_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync,
    output logic primed
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b0;
            fill_q[0]  <= 1'b0;
        end else begin
            chain_q[0] <= d_async;
            fill_q[0]  <= 1'b1;
        end
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[i] <= 1'b0;
                fill_q[i]  <= 1'b0;
            end else begin
                chain_q[i] <= chain_q[i-1];
                fill_q[i]  <= fill_q[i-1];
            end
        end
    end

    assign d_sync = chain_q[STAGES-1];
    assign primed = fill_q[STAGES-1];
endmodule

// File: rtl/pd_prescale.sv
module pd_prescale #(
    parameter int SYNC_STAGES = 2,
    parameter int BASE_P0     = 2,
    parameter int BASE_P1     = 8,
    parameter int BASE_P2     = 512,
    parameter int BASE_P3     = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_clk_async,
    input  logic [1:0] range_sel,
    input  logic       restart,
    output logic       period_stb
);
    localparam int PRE_MAX = pd_pkg::max4(BASE_P0, BASE_P1, BASE_P2, BASE_P3);
    localparam int PRE_W   = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;

    logic             ref_s;
    logic             ref_primed;
    logic             ref_prev_q;
    logic             tick;
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W:0]   lim;
    logic             at_end;

    pd_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ref_clk_async),
        .d_sync  (ref_s),
        .primed  (ref_primed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_prev_q <= 1'b0;
        else        ref_prev_q <= ref_s;
    end

    assign tick = ref_primed & ref_s & ~ref_prev_q;

    always_comb begin
        unique case (range_sel)
            2'b00:   lim = (PRE_W+1)'(BASE_P0);
            2'b01:   lim = (PRE_W+1)'(BASE_P1);
            2'b10:   lim = (PRE_W+1)'(BASE_P2);
            default: lim = (PRE_W+1)'(BASE_P3);
        endcase
    end

    assign at_end     = ({1'b0, cnt_q} == (lim - 1'b1));
    assign period_stb = tick & at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (tick)    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import pd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din_s,
    input  logic             primed,
    input  logic             period_stb,
    input  logic [1:0]       cfg_mode,
    input  logic [CNT_W-1:0] cfg_count,
    output logic             restart,
    output logic             level_q
);
    pd_state_e        state_q, state_d;
    pd_mode_e         mode;
    logic [CNT_W-1:0] win_q;
    logic             pass_now;
    logic             last_period;
    logic             load;
    logic             win_inc;

    assign mode     = pd_mode_e'(cfg_mode);
    assign pass_now = (mode == FLT_OFF) || (cfg_count == '0)
                   || ((mode == FLT_KEEP_LOW)  && !din_s)
                   || ((mode == FLT_KEEP_HIGH) &&  din_s);
    assign last_period = (({1'b0, win_q} + 1'b1) >= {1'b0, cfg_count});

    // next state: LOAD_FIRST, ACCEPT_NOW, START_WINDOW, ABANDON, COMMIT
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        win_inc = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                if (primed) begin
                    state_d = ST_STABLE;
                    load    = 1'b1;
                end
            end
            ST_STABLE: begin
                if (din_s != level_q) begin
                    if (pass_now) load    = 1'b1;
                    else          state_d = ST_QUAL;
                end
            end
            ST_QUAL: begin
                if (din_s == level_q) begin
                    state_d = ST_STABLE;
                end else if (pass_now) begin
                    state_d = ST_STABLE;
                    load    = 1'b1;
                end else if (period_stb) begin
                    if (last_period) begin
                        state_d = ST_STABLE;
                        load    = 1'b1;
                    end else begin
                        win_inc = 1'b1;
                    end
                end
            end
            default: state_d = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            win_q   <= '0;
        end else begin
            if (load) level_q <= din_s;
            if (state_q == ST_QUAL && state_d == ST_QUAL) begin
                if (win_inc) win_q <= win_q + 1'b1;
            end else begin
                win_q <= '0;
            end
        end
    end

    assign restart = (state_q != ST_QUAL);
endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int BASE_P0     = 2,
    parameter int BASE_P1     = 8,
    parameter int BASE_P2     = 512,
    parameter int BASE_P3     = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async,
    input  logic             ref_clk_async,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_unit,
    input  logic             cfg_large,
    input  logic [1:0]       cfg_mode,
    output logic             level_out
);
    logic din_s;
    logic pin_primed;
    logic period_stb;
    logic restart;

    pd_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_async),
        .d_sync  (din_s),
        .primed  (pin_primed)
    );

    pd_prescale #(
        .SYNC_STAGES (SYNC_STAGES),
        .BASE_P0     (BASE_P0),
        .BASE_P1     (BASE_P1),
        .BASE_P2     (BASE_P2),
        .BASE_P3     (BASE_P3)
    ) u_pre (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_clk_async (ref_clk_async),
        .range_sel     ({cfg_large, cfg_unit}),
        .restart       (restart),
        .period_stb    (period_stb)
    );

    pd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .din_s      (din_s),
        .primed     (pin_primed),
        .period_stb (period_stb),
        .cfg_mode   (cfg_mode),
        .cfg_count  (cfg_count),
        .restart    (restart),
        .level_q    (level_out)
    );
endmodule

// File: rtl/pd_checker.sv
module pd_checker
    import pd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             din_s,
    input logic             level_out,
    input logic [1:0]       cfg_mode,
    input logic [CNT_W-1:0] cfg_count,
    input logic [1:0]       state
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_LOW: assert (level_out == 1'b0); // R1
        end
    end

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 && state != ST_INIT) |=> (level_out == $past(din_s))); // R2

    AST_MOVES_TO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_out) |-> (level_out == $past(din_s))); // R3

    AST_KEEP_LOW_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && state == ST_STABLE && !din_s) |=> !level_out); // R5

    AST_KEEP_HIGH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && state == ST_STABLE && din_s) |=> level_out); // R6

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != 2'd0 && cfg_count == '0 && state == ST_STABLE)
        |=> (level_out == $past(din_s))); // R8
endmodule

bind pin_deglitch pd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_s     (din_s),
    .level_out (level_out),
    .cfg_mode  (cfg_mode),
    .cfg_count (cfg_count),
    .state     (u_fsm.state_q)
);

// File: tb/sim_pin_deglitch.sv
`timescale 1ns/1ps
module sim_pin_deglitch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_async = 1'b1;
    logic       ref_clk_async = 1'b0;
    logic [3:0] cfg_count = 4'd0;
    logic       cfg_unit = 1'b0;
    logic       cfg_large = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       level_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always #20 ref_clk_async = ~ref_clk_async;

    pin_deglitch u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_async     (pin_async),
        .ref_clk_async (ref_clk_async),
        .cfg_count     (cfg_count),
        .cfg_unit      (cfg_unit),
        .cfg_large     (cfg_large),
        .cfg_mode      (cfg_mode),
        .level_out     (level_out)
    );

    task automatic expect_lvl(input logic exp, input string tag);
        n_checks++;
        if (level_out !== exp) begin
            n_errors++;
            $display("FAIL %s level_out=%0b expected %0b", tag, level_out, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        pin_async = v;
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [3:0] c,
                           input logic lg, input logic un);
        @(negedge clk);
        cfg_mode  = m;
        cfg_count = c;
        cfg_large = lg;
        cfg_unit  = un;
    endtask

    // filtered change needing nt ticks: lands 4*nt..4*nt+3 edges after drive
    task automatic filtered_edge(input logic v, input int nt, input string tag);
        set_pin(v);
        step(4 * nt - 3);
        expect_lvl(~v, {tag, " before window"});
        step(9);
        expect_lvl(v, {tag, " after window"});
    endtask

    task automatic t_reset;
        pin_async = 1'b1;
        rst_n = 1'b0;
        step(5);
        expect_lvl(1'b0, "R1 held in reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(4);
        expect_lvl(1'b1, "R1 first synchronised value");
    endtask

    task automatic t_bypass;
        set_cfg(2'd0, 4'd5, 1'b0, 1'b0);
        set_pin(1'b0);
        step(3);
        expect_lvl(1'b0, "R2 fall after three edges");
        step(5);
        set_pin(1'b1);
        set_pin(1'b0);
        step(2);
        expect_lvl(1'b1, "R2 one-cycle pulse visible");
        step(1);
        expect_lvl(1'b0, "R2 one-cycle pulse ends");
    endtask

    task automatic t_reject;
        set_cfg(2'd3, 4'd2, 1'b0, 1'b0);
        set_pin(1'b1);
        step(5);
        set_pin(1'b0);
        step(40);
        expect_lvl(1'b0, "R3 short high pulse removed");
        filtered_edge(1'b1, 4, "R3 rise");
        filtered_edge(1'b0, 4, "R3 fall");
        set_pin(1'b0);
        set_pin(1'b1);
        step(5);
        set_pin(1'b0);
        step(40);
        expect_lvl(1'b0, "R3 second short pulse removed");
    endtask

    task automatic t_restart;
        set_pin(1'b1);
        step(11);
        set_pin(1'b0);
        step(1);
        set_pin(1'b1);
        step(13);
        expect_lvl(1'b0, "R4 window restarted after reversal");
        step(9);
        expect_lvl(1'b1, "R4 commit after full fresh window");
        set_pin(1'b0);
        step(30);
        expect_lvl(1'b0, "R4 back to low");
    endtask

    task automatic t_keep_low;
        set_cfg(2'd1, 4'd2, 1'b0, 1'b0);
        filtered_edge(1'b1, 4, "R5 rise filtered");
        set_pin(1'b0);
        step(3);
        expect_lvl(1'b0, "R5 fall passes at once");
        set_pin(1'b1);
        step(5);
        set_pin(1'b0);
        step(40);
        expect_lvl(1'b0, "R5 short high pulse removed");
    endtask

    task automatic t_keep_high;
        set_cfg(2'd2, 4'd2, 1'b0, 1'b0);
        set_pin(1'b1);
        step(3);
        expect_lvl(1'b1, "R6 rise passes at once");
        set_pin(1'b0);
        step(5);
        set_pin(1'b1);
        step(40);
        expect_lvl(1'b1, "R6 short low pulse removed");
        filtered_edge(1'b0, 4, "R6 fall filtered");
    endtask

    task automatic t_zero;
        set_cfg(2'd3, 4'd0, 1'b1, 1'b1);
        set_pin(1'b1);
        step(3);
        expect_lvl(1'b1, "R8 zero count rise");
        set_pin(1'b0);
        step(3);
        expect_lvl(1'b0, "R8 zero count fall");
    endtask

    task automatic t_range(input logic lg, input logic un, input logic [3:0] c,
                           input int base, input string tag);
        set_cfg(2'd3, c, lg, un);
        filtered_edge(1'b1, base * int'(c), tag);
        set_pin(1'b0);
        step(4 * base * int'(c) + 20);
        expect_lvl(1'b0, {tag, " return low"});
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_reject();
        t_restart();
        t_keep_low();
        t_keep_high();
        t_zero();
        t_range(1'b0, 1'b0, 4'd15, 2,    "R7 range 00 count 15");
        t_range(1'b0, 1'b1, 4'd2,  8,    "R7 range 01 count 2");
        t_range(1'b1, 1'b0, 4'd1,  512,  "R7 range 10 count 1");
        t_range(1'b1, 1'b1, 4'd1,  2048, "R7 range 11 count 1");
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired level_out=%0b expected completion", level_out);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule